// File: doc/BRIEF.md
# Delay Line Two-Point Calibration Controller

This block drives the control code of an external DAC-programmed analog delay generator and keeps that generator calibrated against a 10 MHz reference clock. On each one-pulse-per-second strobe it turns a requested delay into a DAC code, applies that code and fires the trigger for the live pulse. It then uses the quiet rest of the second to measure the generator. A 12-step successive-approximation search finds the code whose delay just reaches one reference period (100 ns). A second search finds the code that reaches two periods (200 ns). An external flip-flop and synchronizer judge each trial edge and return a single early/late bit.

The two recorded codes give a linear model of the generator: gain is the code span of one period and offset is the code at zero delay. Both values are held in signed fixed point and smoothed by a shift-weighted exponential average. The first good calibration after reset loads the raw values. A search that ends at either end of the code range means the sample never changed. In that case a sticky error flag is raised and the previous model is kept. All pins are plain control and status pins. The requested delay is sampled only on the PPS strobe, so it needs no handshake and has no back-pressure.

Top module: `delay_cal_ctrl`

## Requirements
- R1: After reset, dac_o, trig_o, cal_busy_o, cal_target_o and cal_err_o are 0, and gain_o and offset_o are 0.
- R2: On the clock edge that samples pps_i high, dac_o takes the converted code of req_delay_i and trig_o is high for the following cycle.
- R3: Outside calibration, dac_o keeps the code applied at the last PPS until the next PPS, and it returns to that code when a calibration ends.
- R4: cal_busy_o rises HOLD_CYC clock edges after the PPS edge. The first search runs with cal_target_o=0 (one period), then the second with cal_target_o=1 (two periods). cal_target_o is only high while cal_busy_o is high.
- R5: Each search tries 12 codes, most significant bit first, starting at 2048. Each trial code is shown on dac_o for SETTLE cycles, with a one-cycle trig_o in its first cycle. A tried bit is kept when early_i=1 (the delayed edge came before the reference edge) and cleared otherwise. The result is the largest code whose delay is early.
- R6: With first-point code c1 and second-point code c2, raw gain = c2 - c1 and raw offset = c1 - gain. Both are reported on gain_o/offset_o as signed values with FRAC=4 fractional bits.
- R7: The first error-free calibration after reset loads the raw values (value × 16). Each later one sets avg = avg + ((raw×16 - avg) >>> K), with an arithmetic (flooring) shift and K=3.
- R8: If either code is 0 or 4095, or c2 <= c1, cal_err_o is set and stays set, and gain_o/offset_o do not change.
- R9: The converted code is floor((offset_o + floor(gain_o × req_delay_i / PERIOD_UNITS)) / 16), with PERIOD_UNITS=100 request units per period, saturated to 0..4095.
- R10: A PPS that arrives while cal_busy_o is high aborts the search without updating the model. It applies the new live code and starts the hold and calibration again.
- R11: gain_o and offset_o never change on the edge that follows a cycle with cal_busy_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (10 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| pps_i | input | 1 | One-cycle PPS strobe, already synchronized |
| early_i | input | 1 | Synchronized coincidence sample: 1 = delayed edge before reference edge |
| req_delay_i | input | 16 | Requested delay in units of 1/PERIOD_UNITS period, sampled on PPS |
| dac_o | output | 12 | Control code to the delay DAC |
| trig_o | output | 1 | Start strobe to the delay generator |
| cal_busy_o | output | 1 | A calibration search is in progress |
| cal_target_o | output | 1 | Coincidence target: 0 = one period, 1 = two periods |
| cal_err_o | output | 1 | Sticky calibration error |
| gain_o | output | 18 | Smoothed gain, signed, 4 fractional bits |
| offset_o | output | 18 | Smoothed offset, signed, 4 fractional bits |

## Verification
The hardest states to reach from the pins are the failed calibration and the aborted search. A failure needs a sample that never toggles over the whole code range. The bench's behavioural delay model can be switched to a stuck-early or stuck-late output, and the bench then checks that the error stays set and the model stays frozen. To abort a search, the bench issues a second PPS part-way through a search, counted from the observed rise of cal_busy_o. To check the exponential average on a non-trivial step, the bench swaps the delay model between two different linear gains and offsets.

// File: rtl/dcal_pkg.sv
package dcal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_PT1,
    ST_PT2,
    ST_UPD
  } seq_t;
endpackage

// File: rtl/dcal_sar.sv
// Successive-approximation search over the DAC code, MSB first.
module dcal_sar #(
  parameter int CODE_W = 12,
  parameter int SETTLE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              early,
  output logic [CODE_W-1:0] code,
  output logic              trig,
  output logic              done
);
  localparam int BW = $clog2(CODE_W);
  localparam int CW = $clog2(SETTLE + 1);

  logic          busy;
  logic [BW-1:0] bitpos;
  logic [CW-1:0] cnt;
  logic          accept;

  assign accept = busy && (cnt == CW'(SETTLE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      bitpos <= '0;
      cnt    <= '0;
      code   <= '0;
      trig   <= 1'b0;
      done   <= 1'b0;
    end else begin
      trig <= 1'b0;
      done <= 1'b0;
      if (abort) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else if (start) begin
        busy   <= 1'b1;
        bitpos <= BW'(CODE_W - 1);
        cnt    <= '0;
        code   <= {1'b1, {(CODE_W-1){1'b0}}};
        trig   <= 1'b1;
      end else if (busy) begin
        if (accept) begin
          code[bitpos] <= early;
          cnt          <= '0;
          if (bitpos == '0) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            code[bitpos - BW'(1)] <= 1'b1;
            bitpos                <= bitpos - BW'(1);
            trig                  <= 1'b1;
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/dcal_smooth.sv
// Shift-weighted exponential average in signed fixed point.
module dcal_smooth #(
  parameter int RW   = 14,
  parameter int FRAC = 4,
  parameter int K    = 3,
  parameter int VW   = RW + FRAC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 first,
  input  logic signed [RW-1:0] raw,
  output logic signed [VW-1:0] avg
);
  logic signed [VW-1:0] raw_ext, raw_f, diff, next_v;

  always_comb begin
    raw_ext = {{(VW-RW){raw[RW-1]}}, raw};
    raw_f   = raw_ext <<< FRAC;
    diff    = raw_f - avg;
    next_v  = avg + (diff >>> K);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  avg <= '0;
    else if (en) avg <= first ? raw_f : next_v;
  end
endmodule

// File: rtl/dcal_conv.sv
// Requested delay to DAC code through the linear model, saturated.
module dcal_conv #(
  parameter int CODE_W       = 12,
  parameter int VW           = 18,
  parameter int FRAC         = 4,
  parameter int REQ_W        = 16,
  parameter int PERIOD_UNITS = 100
) (
  input  logic signed [VW-1:0]  gain_f,
  input  logic signed [VW-1:0]  offset_f,
  input  logic [REQ_W-1:0]      req,
  output logic [CODE_W-1:0]     code
);
  localparam int PW = VW + REQ_W + 1;
  localparam logic signed [PW-1:0] DIV  = PW'(PERIOD_UNITS);
  localparam logic signed [PW-1:0] MAXC = PW'((1 << CODE_W) - 1);

  logic signed [PW-1:0] g_ext, o_ext, r_ext, prod, term, sum, whole;

  always_comb begin
    g_ext = {{(PW-VW){gain_f[VW-1]}}, gain_f};
    o_ext = {{(PW-VW){offset_f[VW-1]}}, offset_f};
    r_ext = {{(PW-REQ_W){1'b0}}, req};
    prod  = g_ext * r_ext;
    term  = prod / DIV;
    sum   = o_ext + term;
    whole = sum >>> FRAC;
    if (whole[PW-1])       code = '0;
    else if (whole > MAXC) code = '1;
    else                   code = whole[CODE_W-1:0];
  end
endmodule

// File: rtl/delay_cal_ctrl.sv
module delay_cal_ctrl
  import dcal_pkg::*;
#(
  parameter int CODE_W       = 12,
  parameter int REQ_W        = 16,
  parameter int FRAC         = 4,
  parameter int AVG_K        = 3,
  parameter int SETTLE       = 8,
  parameter int HOLD_CYC     = 4,
  parameter int PERIOD_UNITS = 100
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          pps_i,
  input  logic                          early_i,
  input  logic [REQ_W-1:0]              req_delay_i,
  output logic [CODE_W-1:0]             dac_o,
  output logic                          trig_o,
  output logic                          cal_busy_o,
  output logic                          cal_target_o,
  output logic                          cal_err_o,
  output logic signed [CODE_W+FRAC+1:0] gain_o,
  output logic signed [CODE_W+FRAC+1:0] offset_o
);
  localparam int RW = CODE_W + 2;
  localparam int VW = RW + FRAC;
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  seq_t              st;
  logic [HW-1:0]     hold_cnt;
  logic [CODE_W-1:0] live_code, code1, code2, sar_code, conv_code;
  logic              live_trig, primed, err_q;
  logic              sar_start, sar_trig, sar_done, hold_end, pt_bad, upd_en, busy;
  logic signed [RW-1:0] raw_gain, raw_off;
  logic signed [RW-1:0] raw_v [2];
  logic signed [VW-1:0] avg_v [2];

  assign busy      = (st == ST_PT1) || (st == ST_PT2);
  assign hold_end  = (st == ST_HOLD) && (hold_cnt == HW'(HOLD_CYC - 1));
  assign sar_start = !pps_i && (hold_end || ((st == ST_PT1) && sar_done));
  assign pt_bad    = (code1 == '0) || (code1 == CODE_MAX) ||
                     (code2 == '0) || (code2 == CODE_MAX) || (code2 <= code1);
  assign upd_en    = (st == ST_UPD) && !pt_bad;
  assign raw_gain  = $signed({2'b00, code2}) - $signed({2'b00, code1});
  assign raw_off   = $signed({2'b00, code1}) - raw_gain;
  assign raw_v[0]  = raw_gain;
  assign raw_v[1]  = raw_off;

  dcal_sar #(.CODE_W(CODE_W), .SETTLE(SETTLE)) u_sar (
    .clk(clk), .rst_n(rst_n), .start(sar_start), .abort(pps_i),
    .early(early_i), .code(sar_code), .trig(sar_trig), .done(sar_done)
  );

  for (genvar gi = 0; gi < 2; gi++) begin : g_avg
    dcal_smooth #(.RW(RW), .FRAC(FRAC), .K(AVG_K), .VW(VW)) u_avg (
      .clk(clk), .rst_n(rst_n), .en(upd_en), .first(!primed),
      .raw(raw_v[gi]), .avg(avg_v[gi])
    );
  end

  dcal_conv #(.CODE_W(CODE_W), .VW(VW), .FRAC(FRAC), .REQ_W(REQ_W),
              .PERIOD_UNITS(PERIOD_UNITS)) u_conv (
    .gain_f(avg_v[0]), .offset_f(avg_v[1]), .req(req_delay_i), .code(conv_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      hold_cnt  <= '0;
      live_code <= '0;
      live_trig <= 1'b0;
      code1     <= '0;
      code2     <= '0;
      primed    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      live_trig <= 1'b0;
      if (pps_i) begin
        live_code <= conv_code;
        live_trig <= 1'b1;
        st        <= ST_HOLD;
        hold_cnt  <= '0;
      end else begin
        case (st)
          ST_HOLD: if (hold_end) st <= ST_PT1;
                   else hold_cnt <= hold_cnt + HW'(1);
          ST_PT1:  if (sar_done) begin code1 <= sar_code; st <= ST_PT2; end
          ST_PT2:  if (sar_done) begin code2 <= sar_code; st <= ST_UPD; end
          ST_UPD:  begin
                     if (pt_bad) err_q <= 1'b1;
                     else        primed <= 1'b1;
                     st <= ST_IDLE;
                   end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign dac_o        = busy ? sar_code : live_code;
  assign trig_o       = live_trig | sar_trig;
  assign cal_busy_o   = busy;
  assign cal_target_o = (st == ST_PT2);
  assign cal_err_o    = err_q;
  assign gain_o       = avg_v[0];
  assign offset_o     = avg_v[1];
endmodule

// File: rtl/delay_cal_ctrl_chk.sv
module delay_cal_ctrl_chk #(
  parameter int CODE_W = 12,
  parameter int VW     = 18
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pps_i,
  input logic [CODE_W-1:0]    dac_o,
  input logic                 trig_o,
  input logic                 cal_busy_o,
  input logic                 cal_target_o,
  input logic                 cal_err_o,
  input logic signed [VW-1:0] gain_o,
  input logic signed [VW-1:0] offset_o
);
  assert_pps_trig_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pps_i |=> trig_o);

  assert_live_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_busy_o && !pps_i) |=> (cal_busy_o || $stable(dac_o)));

  assert_target_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cal_target_o |-> cal_busy_o);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cal_err_o |=> cal_err_o);

  assert_err_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_err_o) |-> ($stable(gain_o) && $stable(offset_o)));

  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy_o && pps_i) |=> !cal_busy_o);

  assert_frozen_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy_o |=> ($stable(gain_o) && $stable(offset_o)));
endmodule

bind delay_cal_ctrl delay_cal_ctrl_chk #(.CODE_W(CODE_W), .VW(CODE_W + 2 + FRAC)) u_chk (
  .clk(clk), .rst_n(rst_n), .pps_i(pps_i), .dac_o(dac_o), .trig_o(trig_o),
  .cal_busy_o(cal_busy_o), .cal_target_o(cal_target_o), .cal_err_o(cal_err_o),
  .gain_o(gain_o), .offset_o(offset_o)
);

// File: tb/sim_delay_cal_ctrl.sv
`timescale 1ns/1ps
module sim_delay_cal_ctrl;
  localparam int CLK_PERIOD = 100;
  localparam int HOLD       = 4;
  localparam int SETTLE     = 8;
  localparam int WD_CYCLES  = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pps_i = 1'b0;
  logic        early_i;
  logic [15:0] req_delay_i = '0;
  logic [11:0] dac_o;
  logic        trig_o, cal_busy_o, cal_target_o, cal_err_o;
  logic signed [17:0] gain_o, offset_o;

  int n_checks = 0;
  int n_err = 0;
  int mode = 0;      // 0: model A, 1: model B, 2: stuck early, 3: stuck late
  int d0 = 20000;    // ps
  int slope = 50;    // ps per code

  longint exp_g = 0, exp_o = 0;
  bit primed_b = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  delay_cal_ctrl #(.SETTLE(SETTLE), .HOLD_CYC(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .pps_i(pps_i), .early_i(early_i),
    .req_delay_i(req_delay_i), .dac_o(dac_o), .trig_o(trig_o),
    .cal_busy_o(cal_busy_o), .cal_target_o(cal_target_o), .cal_err_o(cal_err_o),
    .gain_o(gain_o), .offset_o(offset_o)
  );

  // Behavioural delay generator plus coincidence flip-flop.
  always_comb begin
    int tgt, dly;
    tgt = cal_target_o ? 200000 : 100000;
    dly = d0 + slope * int'(dac_o);
    if (mode == 2)      early_i = 1'b1;
    else if (mode == 3) early_i = 1'b0;
    else                early_i = (dly < tgt);
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint point_code(input int dz, input int s, input int tgt);
    longint v;
    v = (tgt - dz - 1) / s;
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    return v;
  endfunction

  function automatic longint conv_exp(input longint gf, input longint of, input longint req);
    longint s;
    s = (of + (gf * req) / 100) >>> 4;
    if (s < 0) s = 0;
    if (s > 4095) s = 4095;
    return s;
  endfunction

  // Model update after one calibration with the current linear model (R6, R7).
  task automatic expect_update();
    longint c1, c2, rg, ro;
    c1 = point_code(d0, slope, 100000);
    c2 = point_code(d0, slope, 200000);
    rg = c2 - c1;
    ro = c1 - rg;
    if (!primed_b) begin
      exp_g = rg * 16;
      exp_o = ro * 16;
      primed_b = 1'b1;
    end else begin
      exp_g = exp_g + ((rg * 16 - exp_g) >>> 3);
      exp_o = exp_o + ((ro * 16 - exp_o) >>> 3);
    end
  endtask

  task automatic pulse_pps(input int req);
    @(negedge clk);
    req_delay_i = 16'(req);
    pps_i = 1'b1;
    @(negedge clk);
    pps_i = 1'b0;
  endtask

  task automatic wait_cal();
    while (!cal_busy_o) @(negedge clk);
    while (cal_busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WD_CYCLES, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    longint lv, g_keep, o_keep;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(dac_o == 0 && trig_o == 0 && cal_busy_o == 0, "R1 outputs idle", dac_o, 0);
    check(cal_err_o == 0 && cal_target_o == 0, "R1 flags clear", cal_err_o, 0);
    check(gain_o == 0 && offset_o == 0, "R1 model zero", gain_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // First PPS with unprimed model: code 0, trigger (R2)
    pulse_pps(50);
    check(dac_o == 0, "R2 first live code", dac_o, 0);
    check(trig_o == 1, "R2 live trigger", trig_o, 1);
    @(negedge clk);
    check(trig_o == 0, "R2 trigger one cycle", trig_o, 0);
    // R4: busy after HOLD edges, first target one period
    repeat (HOLD - 2) @(negedge clk);
    check(cal_busy_o == 0, "R4 hold not over", cal_busy_o, 0);
    @(negedge clk);
    check(cal_busy_o == 1 && cal_target_o == 0, "R4 first search target", cal_target_o, 0);
    // R5: MSB trial with trigger, held SETTLE cycles
    check(dac_o == 2048 && trig_o == 1, "R5 MSB trial", dac_o, 2048);
    @(negedge clk);
    check(trig_o == 0 && dac_o == 2048, "R5 trial held", dac_o, 2048);
    repeat (SETTLE - 1) @(negedge clk);
    check(dac_o == 1024 && trig_o == 1, "R5 late MSB cleared", dac_o, 1024);
    while (!cal_target_o) @(negedge clk);
    check(dac_o == 2048 && cal_busy_o == 1, "R4 second search starts", dac_o, 2048);
    wait_cal();
    expect_update();
    check(longint'(gain_o) == exp_g, "R6 R7 first gain load", gain_o, exp_g);
    check(longint'(offset_o) == exp_o, "R6 R7 first offset load", offset_o, exp_o);
    check(cal_err_o == 0, "R8 no error on good model", cal_err_o, 0);
    check(dac_o == 0, "R3 live code restored", dac_o, 0);

    // R9 sweep of requested delay under model A
    for (int r = 0; r <= 300; r += 2) begin
      pulse_pps(r);
      lv = conv_exp(exp_g, exp_o, r);
      check(longint'(dac_o) == lv, $sformatf("R9 conversion req=%0d", r), dac_o, lv);
      begin
        longint tru, df;
        tru = (longint'(r) * 1000 - d0) / slope;
        if (tru < 0) tru = 0;
        if (tru > 4095) tru = 4095;
        df = longint'(dac_o) - tru;
        check(df <= 1 && df >= -1, $sformatf("R9 within one LSB req=%0d", r), dac_o, tru);
      end
      wait_cal();
      check(longint'(dac_o) == lv, $sformatf("R3 code held req=%0d", r), dac_o, lv);
      expect_update();
    end
    check(longint'(gain_o) == exp_g, "R7 steady gain", gain_o, exp_g);

    // R10: PPS in the middle of a search
    pulse_pps(100);
    while (!cal_busy_o) @(negedge clk);
    repeat (20) @(negedge clk);
    g_keep = gain_o;
    pulse_pps(150);
    lv = conv_exp(exp_g, exp_o, 150);
    check(cal_busy_o == 0, "R10 search aborted", cal_busy_o, 0);
    check(longint'(dac_o) == lv, "R10 new live code", dac_o, lv);
    repeat (3) @(negedge clk);
    check(longint'(gain_o) == g_keep, "R10 model unchanged", gain_o, g_keep);
    wait_cal();
    expect_update();
    check(longint'(gain_o) == exp_g, "R10 restarted calibration", gain_o, exp_g);

    // R7: smoothing toward model B
    mode = 1; d0 = 10000; slope = 60;
    pulse_pps(120);
    wait_cal();
    expect_update();
    check(longint'(gain_o) == exp_g, "R7 averaged gain", gain_o, exp_g);
    check(longint'(offset_o) == exp_o, "R7 averaged offset", offset_o, exp_o);

    // R8: stuck-early and stuck-late samples
    g_keep = gain_o; o_keep = offset_o;
    mode = 2;
    pulse_pps(120);
    wait_cal();
    check(cal_err_o == 1, "R8 stuck early flags error", cal_err_o, 1);
    check(longint'(gain_o) == g_keep && longint'(offset_o) == o_keep, "R8 model kept", gain_o, g_keep);
    mode = 3;
    pulse_pps(120);
    wait_cal();
    check(longint'(gain_o) == g_keep && longint'(offset_o) == o_keep, "R8 stuck late model kept", offset_o, o_keep);
    mode = 0; d0 = 20000; slope = 50;
    pulse_pps(120);
    wait_cal();
    expect_update();
    check(cal_err_o == 1, "R8 error sticky", cal_err_o, 1);
    check(longint'(gain_o) == exp_g, "R7 update after error", gain_o, exp_g);
    check(longint'(offset_o) == exp_o, "R7 offset after error", offset_o, exp_o);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule